// File: doc/BRIEF.md
# Five-Pin GPIO Port with Serial and Oscillator Hand-Over

This block is a small general-purpose I/O port of five pins. Each pin has a bit in an output-value latch and a bit in a direction register. Software reaches both registers over a byte-wide bus that has a write strobe and one select line for each register. The block drives an output-enable and an output value for every pin. It also returns read data combinationally from whichever register is selected.

Two pins can be lent to a serial unit. While `ser_en` is high, pin 0 carries the transmit bit and pin 1 feeds the receiver. Two more pins can be lent to a clock oscillator. While `osc_en` is high, pin 3 drives the oscillator's clock output and pin 4 carries the clock input. During a serial loan the pin direction comes from the serial function. The direction register still decides whether a data read returns the latch or the pin level.

Pin levels are sampled through a two-stage synchronizer before they are read back or passed to the serial receiver. The value latch has no reset. The direction register clears on reset.

Top module: `gpio_lend_port`

## Requirements
- R1: While `rst` is high at a clock edge, the direction register clears to 0. After reset, with both loans off, every `pin_oe` bit is 0.
- R2: With no loan active on a pin, `pin_oe[i]` equals direction bit i and `pin_out[i]` equals latch bit i.
- R3: Reset leaves the value latch unchanged. `pin_out` and a later read with direction 1 still show the value written before reset.
- R4: While `ser_en` is 1, `pin_oe[0]` is 1 and `pin_out[0]` follows `ser_txd`. In the same mode `pin_oe[1]` is 0 and `ser_rxd` is the synchronized level of pin 1. Both hold whatever the direction bits 0 and 1 are.
- R5: While `ser_en` is 0, pins 0 and 1 follow R2.
- R6: A read with `sel_val` high returns, in bits 4..0, latch bit i where direction bit i is 1 and the synchronized pin level where it is 0. This also holds for pins 0 and 1 during a serial loan.
- R7: While `osc_en` is 1, `pin_oe[3]` is 1 and `pin_out[3]` equals `osc_clk_out`. `pin_oe[4]` is 0 and `osc_clk_in` equals `pin_in[4]`. Writes to latch bits 3 and 4 are ignored, and those bits read as 0.
- R8: Read-data bits 7..5 are always 0. A read with `sel_dir` high, and `sel_val` low, returns the direction register in bits 4..0.
- R9: A write is stored at the clock edge where `bus_wr` and a select are high, so it is visible from the next cycle. A pin level reaches read data and `ser_rxd` after the second rising edge that samples it.
- R10: With neither select high, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| sel_val | input | 1 | Selects the value latch (has read priority) |
| sel_dir | input | 1 | Selects the direction register |
| bus_wdata | input | 8 | Write data, bits 4..0 used |
| bus_rdata | output | 8 | Read data of the selected register |
| ser_en | input | 1 | Lends pins 0 and 1 to the serial unit |
| ser_txd | input | 1 | Serial transmit bit for pin 0 |
| ser_rxd | output | 1 | Synchronized pin 1 level for the receiver |
| osc_en | input | 1 | Lends pins 3 and 4 to the oscillator |
| osc_clk_out | input | 1 | Clock to drive on pin 3 |
| osc_clk_in | output | 1 | Raw pin 4 level for the oscillator |
| pin_in | input | 5 | Pad input levels |
| pin_oe | output | 5 | Pad output enables |
| pin_out | output | 5 | Pad output values |

## Verification
A write becomes visible at the outputs one rising edge after the strobe. A pin level becomes visible two rising edges after it is first sampled. Loan enables, `ser_txd`, `osc_clk_out` and the selects act in the same cycle, through combinational paths.

The bench drives inputs on the falling edge and updates a behavioural model at each rising edge. It then compares every output five time units later, so each result is checked in the cycle it is due. Latch bits that have never been written are left out of the comparison until a write defines them.

// File: rtl/gpio_lend_pkg.sv
package gpio_lend_pkg;
    localparam int PIN_W   = 5;
    localparam int REG_W   = 8;
    localparam int TX_PIN  = 0;
    localparam int RX_PIN  = 1;
    localparam int CKO_PIN = 3;
    localparam int CKI_PIN = 4;

    typedef logic [PIN_W-1:0] pin_vec_t;

    typedef struct packed {
        pin_vec_t oe;
        pin_vec_t val;
    } pin_drive_t;

    // pins taken by the oscillator loan
    function automatic pin_vec_t osc_pins();
        pin_vec_t m;
        m = '0;
        m[CKO_PIN] = 1'b1;
        m[CKI_PIN] = 1'b1;
        return m;
    endfunction

    function automatic logic [REG_W-1:0] widen(pin_vec_t v);
        return {{(REG_W-PIN_W){1'b0}}, v};
    endfunction
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_chain
        always_ff @(posedge clk) begin
            if (rst) stage[s] <= '0;
            else     stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_lend_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_val,
    input  logic     wr_dir,
    input  pin_vec_t wdata,
    input  logic     osc_en,
    output pin_vec_t latch_q,
    output pin_vec_t dir_q
);
    pin_vec_t keep;

    assign keep = osc_en ? osc_pins() : '0;

    // value latch: deliberately not reset
    always_ff @(posedge clk) begin
        if (!rst && wr_val)
            latch_q <= (latch_q & keep) | (wdata & ~keep);
    end

    always_ff @(posedge clk) begin
        if (rst)         dir_q <= '0;
        else if (wr_dir) dir_q <= wdata;
    end

    // R1
    dir_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dir_q == '0));

    // R7
    osc_write_block_chk: assert property (@(posedge clk) disable iff (rst)
        (osc_en && wr_val) |=> $stable(latch_q[CKI_PIN:CKO_PIN]));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_lend_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pin_vec_t   latch_q,
    input  pin_vec_t   dir_q,
    input  logic       ser_en,
    input  logic       ser_txd,
    input  logic       osc_en,
    input  logic       osc_clk_out,
    output pin_drive_t drive
);
    always_comb begin
        drive.oe  = dir_q;
        drive.val = latch_q;
        if (ser_en) begin
            drive.oe[TX_PIN]  = 1'b1;
            drive.val[TX_PIN] = ser_txd;
            drive.oe[RX_PIN]  = 1'b0;
        end
        if (osc_en) begin
            drive.oe[CKO_PIN]  = 1'b1;
            drive.val[CKO_PIN] = osc_clk_out;
            drive.oe[CKI_PIN]  = 1'b0;
        end
    end

    // R4
    ser_dir_chk: assert property (@(posedge clk) disable iff (rst)
        ser_en |-> (drive.oe[TX_PIN] && !drive.oe[RX_PIN]
                    && drive.val[TX_PIN] == ser_txd));
endmodule

// File: rtl/gpio_lend_port.sv
module gpio_lend_port
    import gpio_lend_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             sel_val,
    input  logic             sel_dir,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             ser_en,
    input  logic             ser_txd,
    output logic             ser_rxd,
    input  logic             osc_en,
    input  logic             osc_clk_out,
    output logic             osc_clk_in,
    input  logic [PIN_W-1:0] pin_in,
    output logic [PIN_W-1:0] pin_oe,
    output logic [PIN_W-1:0] pin_out
);
    pin_vec_t   latch_q, dir_q, pin_s, rd_pins;
    pin_drive_t drive;
    logic       unused_hi;

    assign unused_hi = ^bus_wdata[REG_W-1:PIN_W];

    gpio_pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(pin_s)
    );

    gpio_port_regs u_regs (
        .clk(clk), .rst(rst),
        .wr_val(bus_wr && sel_val), .wr_dir(bus_wr && sel_dir),
        .wdata(bus_wdata[PIN_W-1:0]), .osc_en(osc_en),
        .latch_q(latch_q), .dir_q(dir_q)
    );

    gpio_pin_mux u_mux (
        .clk(clk), .rst(rst), .latch_q(latch_q), .dir_q(dir_q),
        .ser_en(ser_en), .ser_txd(ser_txd),
        .osc_en(osc_en), .osc_clk_out(osc_clk_out), .drive(drive)
    );

    for (genvar i = 0; i < PIN_W; i++) begin : g_rd
        assign rd_pins[i] = (osc_en && osc_pins()[i]) ? 1'b0
                          : (dir_q[i] ? latch_q[i] : pin_s[i]);
    end

    always_comb begin
        if (sel_val)      bus_rdata = widen(rd_pins);
        else if (sel_dir) bus_rdata = widen(dir_q);
        else              bus_rdata = '0;
    end

    assign pin_oe     = drive.oe;
    assign pin_out    = drive.val;
    assign ser_rxd    = pin_s[RX_PIN];
    assign osc_clk_in = pin_in[CKI_PIN];

    // R8
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[REG_W-1:PIN_W] == '0);

    // R10
    idle_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel_val && !sel_dir) |-> (bus_rdata == '0));
endmodule

// File: tb/gpio_lend_port_test.sv
module gpio_lend_port_test;
    // 50 MHz: 20-unit period
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, sel_val = 1'b0, sel_dir = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ser_en = 1'b0, ser_txd = 1'b0, ser_rxd;
    logic       osc_en = 1'b0, osc_clk_out = 1'b0, osc_clk_in;
    logic [4:0] pin_in = 5'h00, pin_oe, pin_out;

    int vectors = 0;
    int fails   = 0;
    bit armed   = 0;

    // behavioural reference state
    logic [4:0] m_dir = '0, m_latch = '0, m_known = '0;
    logic [4:0] hist [$];

    always #10 clk = ~clk;

    gpio_lend_port uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .sel_val(sel_val),
        .sel_dir(sel_dir), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ser_en(ser_en), .ser_txd(ser_txd), .ser_rxd(ser_rxd),
        .osc_en(osc_en), .osc_clk_out(osc_clk_out), .osc_clk_in(osc_clk_in),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    task automatic cmp(string what, string req, logic [7:0] act,
                       logic [7:0] exp, logic [7:0] mask);
        vectors++;
        if ((act & mask) !== (exp & mask)) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h (mask %h) at %0t",
                     req, what, act, exp, mask, $time);
        end
    endtask

    always @(posedge clk) begin
        logic [4:0] oe_e, out_e, out_m, rd_e, rd_m, sync_v;
        logic [7:0] rdat_e, rdat_m;
        // model update with inputs held stable across the edge
        if (rst) begin
            armed = 1;
            m_dir = '0;
            hist  = '{5'h00, 5'h00};
        end else begin
            if (bus_wr && sel_val)
                for (int i = 0; i < 5; i++)
                    if (!(osc_en && (i == 3 || i == 4))) begin
                        m_latch[i] = bus_wdata[i];
                        m_known[i] = 1'b1;
                    end
            if (bus_wr && sel_dir) m_dir = bus_wdata[4:0];
            hist.push_back(pin_in);
            if (hist.size() > 2) void'(hist.pop_front());
        end
        #5;
        if (armed) begin
            sync_v = (hist.size() == 2) ? hist[0] : 5'h00;
            oe_e = m_dir; out_e = m_latch; out_m = m_known;
            if (ser_en) begin
                oe_e[0] = 1'b1; oe_e[1] = 1'b0;
                out_e[0] = ser_txd; out_m[0] = 1'b1;
            end
            if (osc_en) begin
                oe_e[3] = 1'b1; oe_e[4] = 1'b0;
                out_e[3] = osc_clk_out; out_m[3] = 1'b1;
            end
            for (int i = 0; i < 5; i++) begin
                rd_e[i] = m_dir[i] ? m_latch[i] : sync_v[i];
                rd_m[i] = m_dir[i] ? m_known[i] : 1'b1;
                if (osc_en && (i == 3 || i == 4)) begin
                    rd_e[i] = 1'b0; rd_m[i] = 1'b1;
                end
            end
            if (sel_val) begin
                rdat_e = {3'b000, rd_e}; rdat_m = {3'b111, rd_m};
            end else if (sel_dir) begin
                rdat_e = {3'b000, m_dir}; rdat_m = 8'hFF;
            end else begin
                rdat_e = 8'h00; rdat_m = 8'hFF;
            end
            cmp("pin_oe", "R1 R2 R4 R5 R7", {3'b0, pin_oe}, {3'b0, oe_e}, 8'h1F);
            cmp("pin_out", "R2 R3 R4 R5 R7", {3'b0, pin_out}, {3'b0, out_e}, {3'b0, out_m});
            cmp("bus_rdata", "R6 R7 R8 R9 R10", bus_rdata, rdat_e, rdat_m);
            cmp("ser_rxd", "R4 R9", {7'b0, ser_rxd}, {7'b0, sync_v[1]}, 8'h01);
            cmp("osc_clk_in", "R7", {7'b0, osc_clk_in}, {7'b0, pin_in[4]}, 8'h01);
        end
    end

    task automatic idle(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(bit to_dir, logic [7:0] v);
        @(negedge clk);
        bus_wr = 1'b1; sel_val = !to_dir; sel_dir = to_dir; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0; sel_val = 1'b0; sel_dir = 1'b0;
    endtask

    task automatic look(bit at_dir, int n);
        @(negedge clk);
        sel_val = !at_dir; sel_dir = at_dir;
        idle(n);
        sel_val = 1'b0; sel_dir = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        pin_in = 5'h0A;
        idle(3);
        rst = 1'b0;                        // R1: oe all low
        look(1, 2);                        // R8: direction reads 0
        look(0, 4);                        // R6/R9: pins through sync
        wr(0, 8'hF5);                      // R9: latch written
        wr(1, 8'hFF);                      // R2: all outputs
        look(0, 3);
        look(1, 2);
        wr(1, 8'h05);                      // mixed direction
        pin_in = 5'h1A; look(0, 2);
        pin_in = 5'h04; look(0, 3);
        idle(2);                           // R10
        @(negedge clk); rst = 1'b1;        // R3: reset keeps latch
        idle(2); rst = 1'b0;
        wr(1, 8'h1F); look(0, 3);
        // serial loan, R4 / R5 / R6
        wr(1, 8'h02);
        ser_en = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            ser_txd = k[0]; pin_in[1] = k[1]; sel_val = 1'b1;
        end
        wr(1, 8'h01); look(0, 3);
        ser_en = 1'b0; look(0, 2);
        // oscillator loan, R7
        wr(0, 8'h00);
        osc_en = 1'b1;
        wr(0, 8'h1F);                      // bits 3,4 must stay 0
        wr(1, 8'h1F); look(0, 3);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); osc_clk_out = k[0]; pin_in[4] = ~k[0];
        end
        osc_en = 1'b0; look(0, 2);
        // mixed traffic
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            bus_wr    = ($urandom % 3) == 0;
            sel_val   = $urandom % 2;
            sel_dir   = !sel_val && ($urandom % 2);
            bus_wdata = 8'($urandom);
            ser_en    = ($urandom % 4) == 0;
            osc_en    = ($urandom % 4) == 0;
            ser_txd   = $urandom % 2;
            osc_clk_out = $urandom % 2;
            pin_in    = 5'($urandom);
            rst       = ($urandom % 50) == 0;
        end
        @(negedge clk);
        rst = 1'b0; bus_wr = 1'b0; sel_val = 1'b0; sel_dir = 1'b0;
        idle(3);
        finish_run();
    end
endmodule